// File: doc/BRIEF.md
# Two-Register Single-Cycle 8-bit Processor

This block is a small processor that finishes one instruction in every clock cycle. On each rising edge it takes the byte that the program counter points at from its instruction store and classifies it by its upper bits. It then performs the operation on one of its two 8-bit registers, called ra and rb, and moves the program counter on. Code and data live in two separate internal arrays. A test or boot agent fills both arrays through plain write ports. The program counter and both registers can be watched at all times on debug outputs.

The instruction set is small:

- a no-operation;
- four register-to-register operations (and, or, add, sub), in which each operand is picked by a single select bit;
- a load from a 16-word data array, using a 4-bit zero-extended address;
- an OR with a 4-bit zero-extended immediate;
- a branch-if-equal with a 5-bit signed offset.

Every byte that has no defined meaning acts as a no-operation.

Top module: `duo_reg_cpu`

## Requirements
- R1: A synchronous active-high reset sets the program counter, ra and rb to zero on the rising edge at which it is sampled high.
- R2: The byte 0x00 and every undefined byte change only the program counter, which advances by one. Undefined bytes are 0x01..0x1F and the patterns with top bits 011, 100 or 110.
- R3: A byte with top bits 001 is a register-to-register operation. Bits 4:3 select the function: 00 and, 01 or, 10 add, 11 sub. Bit 2 selects the destination, bit 1 the first source and bit 0 the second source, where a select value of 0 means ra and 1 means rb. Add and sub wrap modulo 256 and raise no flags.
- R4: A byte with top bits 010 loads a data word into a register. Bit 4 selects the destination and bits 3:0 give the data address, which is zero-extended.
- R5: A byte with top bits 101 ORs bits 3:0, zero-extended, into the register that bit 4 selects. Bits already set in that register stay set.
- R6: A byte with top bits 111 is a branch-if-equal with bits 4:0 as a signed offset. When ra equals rb, the next PC is PC+1+offset, taken modulo 256. When they differ, the next PC is PC+1.
- R7: The data array changes only through its write port, at the rising edge. A load that executes at the same edge as a port write to the same address returns the word that was stored before that edge.
- R8: The debug outputs show the current program counter, ra and rb in the same cycle they change.
- R9: The program counter wraps from 255 to 0 when it advances by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_we | input | 1 | Instruction array write enable |
| imem_waddr | input | 8 | Instruction array write address |
| imem_wdata | input | 8 | Instruction array write data |
| dmem_we | input | 1 | Data array write enable |
| dmem_waddr | input | 4 | Data array write address |
| dmem_wdata | input | 8 | Data array write data |
| dbg_pc | output | 8 | Current program counter |
| dbg_ra | output | 8 | Current value of ra |
| dbg_rb | output | 8 | Current value of rb |

## Verification
Two of this block's functions can fall on the same edge: a data-array write through the port, and a load instruction that reads the same word. The bench provokes this by releasing reset in the same cycle that it drives a port write to the address used by the first load. A second load of that address follows in the next cycle. The result is judged correct when the first load returns the word stored before the edge and the second load returns the newly written word.

// File: rtl/duo_cpu_pkg.sv
package duo_cpu_pkg;
  localparam int INSN_W  = 8;
  localparam int DATA_W  = 8;
  localparam int PC_W    = 8;
  localparam int DADDR_W = 4;
  localparam int IMM_W   = 4;
  localparam int OFF_W   = 5;
  localparam int NREGS   = 2;

  typedef enum logic [2:0] {
    K_NOP,
    K_ALU,
    K_LOAD,
    K_ORI,
    K_BEQ
  } insn_kind_e;

  typedef enum logic [1:0] {
    F_AND = 2'b00,
    F_OR  = 2'b01,
    F_ADD = 2'b10,
    F_SUB = 2'b11
  } alu_fn_e;

  typedef struct packed {
    insn_kind_e        kind;
    alu_fn_e           fn;
    logic              dst;
    logic              src1;
    logic              src2;
    logic [IMM_W-1:0]  imm;
    logic [OFF_W-1:0]  off;
  } decoded_t;

  function automatic logic [DATA_W-1:0] alu_apply(
    input alu_fn_e fn, input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] r;
    case (fn)
      F_AND:   r = a & b;
      F_OR:    r = a | b;
      F_ADD:   r = a + b;
      default: r = a - b;
    endcase
    return r;
  endfunction

  function automatic logic [PC_W-1:0] sext_off(input logic [OFF_W-1:0] off);
    return {{(PC_W-OFF_W){off[OFF_W-1]}}, off};
  endfunction

  function automatic logic [DATA_W-1:0] zext_imm(input logic [IMM_W-1:0] imm);
    return {{(DATA_W-IMM_W){1'b0}}, imm};
  endfunction

  function automatic logic [PC_W-1:0] next_pc(
    input logic [PC_W-1:0] pc, input logic take, input logic [OFF_W-1:0] off);
    logic [PC_W-1:0] seq;
    seq = pc + PC_W'(1);
    return take ? seq + sext_off(off) : seq;
  endfunction
endpackage

// File: rtl/duo_cpu_mem.sv
module duo_cpu_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

  // R7: a port write lands at the edge, so the word is visible on the next cycle
  a_r7_write_visible: assert property (@(posedge clk)
    we |=> cells[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/duo_cpu_decode.sv
module duo_cpu_decode
  import duo_cpu_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output decoded_t          dec
);
  always_comb begin
    dec       = '0;
    dec.kind  = K_NOP;
    dec.fn    = alu_fn_e'(insn[4:3]);
    dec.imm   = insn[IMM_W-1:0];
    dec.off   = insn[OFF_W-1:0];
    dec.src2  = insn[0];
    unique case (insn[7:5])
      3'b001: begin
        dec.kind = K_ALU;
        dec.dst  = insn[2];
        dec.src1 = insn[1];
      end
      3'b010: begin
        dec.kind = K_LOAD;
        dec.dst  = insn[4];
        dec.src1 = insn[4];
      end
      3'b101: begin
        dec.kind = K_ORI;
        dec.dst  = insn[4];
        dec.src1 = insn[4];
      end
      3'b111: begin
        dec.kind = K_BEQ;
        dec.src1 = 1'b0;
        dec.src2 = 1'b1;
      end
      default: dec.kind = K_NOP;
    endcase
  end
endmodule

// File: rtl/duo_cpu_regs.sv
module duo_cpu_regs
  import duo_cpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              wsel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rsel1,
  input  logic              rsel2,
  output logic [DATA_W-1:0] rd1,
  output logic [DATA_W-1:0] rd2,
  output logic [DATA_W-1:0] reg_a,
  output logic [DATA_W-1:0] reg_b
);
  logic [DATA_W-1:0] bank [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                          bank[g] <= '0;
      else if (we && (int'(wsel) == g)) bank[g] <= wdata;
    end
  end

  assign rd1   = bank[rsel1];
  assign rd2   = bank[rsel2];
  assign reg_a = bank[0];
  assign reg_b = bank[1];

  // R1: both registers read zero after a reset edge
  a_r1_regs_cleared: assert property (@(posedge clk)
    rst |=> (reg_a == '0) && (reg_b == '0));

  // R2: without a write the pair keeps its contents
  a_r2_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(reg_a) && $stable(reg_b));

  // R3: a write reaches only the selected register
  a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
    we |=> (($past(wsel) ? reg_b : reg_a) == $past(wdata)) &&
           ($past(wsel) ? $stable(reg_a) : $stable(reg_b)));
endmodule

// File: rtl/duo_cpu_pc.sv
module duo_cpu_pc
  import duo_cpu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [OFF_W-1:0] off,
  output logic [PC_W-1:0]  pc
);
  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= next_pc(pc, take, off);
  end

  // R1: reset clears the program counter
  a_r1_pc_cleared: assert property (@(posedge clk) rst |=> pc == '0);

  // R6: a taken branch lands at pc+1+offset
  a_r6_taken_target: assert property (@(posedge clk) disable iff (rst)
    take |=> pc == PC_W'($past(pc) + PC_W'(1) + sext_off($past(off))));

  // R2/R6: otherwise the counter steps by one
  a_r6_fall_through: assert property (@(posedge clk) disable iff (rst)
    !take |=> pc == PC_W'($past(pc) + PC_W'(1)));

  // R9: stepping past the top address returns to zero
  a_r9_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (!take && pc == {PC_W{1'b1}}) |=> pc == '0);
endmodule

// File: rtl/duo_reg_cpu.sv
module duo_reg_cpu
  import duo_cpu_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        imem_we,
  input  logic [7:0]  imem_waddr,
  input  logic [7:0]  imem_wdata,
  input  logic        dmem_we,
  input  logic [3:0]  dmem_waddr,
  input  logic [7:0]  dmem_wdata,
  output logic [7:0]  dbg_pc,
  output logic [7:0]  dbg_ra,
  output logic [7:0]  dbg_rb
);
  logic [PC_W-1:0]   pc;
  logic [INSN_W-1:0] insn;
  decoded_t          dec;
  logic [DATA_W-1:0] rd1, rd2, reg_a, reg_b;
  logic [DATA_W-1:0] load_word;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data;
  logic              regs_equal;
  logic              take_branch;

  duo_cpu_mem #(.AW(PC_W), .DW(INSN_W)) u_imem (
    .clk(clk), .we(imem_we), .waddr(imem_waddr), .wdata(imem_wdata),
    .raddr(pc), .rdata(insn)
  );

  duo_cpu_mem #(.AW(DADDR_W), .DW(DATA_W)) u_dmem (
    .clk(clk), .we(dmem_we), .waddr(dmem_waddr), .wdata(dmem_wdata),
    .raddr(dec.imm), .rdata(load_word)
  );

  duo_cpu_decode u_dec (.insn(insn), .dec(dec));

  duo_cpu_regs u_regs (
    .clk(clk), .rst(rst), .we(wr_en), .wsel(dec.dst), .wdata(wr_data),
    .rsel1(dec.src1), .rsel2(dec.src2), .rd1(rd1), .rd2(rd2),
    .reg_a(reg_a), .reg_b(reg_b)
  );

  always_comb begin
    wr_en   = 1'b0;
    wr_data = '0;
    unique case (dec.kind)
      K_ALU:  begin wr_en = 1'b1; wr_data = alu_apply(dec.fn, rd1, rd2); end
      K_LOAD: begin wr_en = 1'b1; wr_data = load_word; end
      K_ORI:  begin wr_en = 1'b1; wr_data = rd1 | zext_imm(dec.imm); end
      default: ;
    endcase
  end

  assign regs_equal  = (reg_a == reg_b);
  assign take_branch = (dec.kind == K_BEQ) && regs_equal;

  duo_cpu_pc u_pc (
    .clk(clk), .rst(rst), .take(take_branch), .off(dec.off), .pc(pc)
  );

  assign dbg_pc = pc;
  assign dbg_ra = reg_a;
  assign dbg_rb = reg_b;

  // R2: a no-operation leaves both registers untouched
  a_r2_nop_regs_stable: assert property (@(posedge clk) disable iff (rst)
    (dec.kind == K_NOP) |=> $stable(dbg_ra) && $stable(dbg_rb));

  // R4: a load writes the word the data array held before the edge
  a_r4_load_value: assert property (@(posedge clk) disable iff (rst)
    (dec.kind == K_LOAD) |=> ($past(dec.dst) ? dbg_rb : dbg_ra) == $past(load_word));

  // R5: the OR-immediate never clears a bit
  a_r5_ori_keeps_bits: assert property (@(posedge clk) disable iff (rst)
    (dec.kind == K_ORI) |=>
      ((($past(dec.dst) ? dbg_rb : dbg_ra) & $past(rd1)) == $past(rd1)));

  // R6: a branch never writes a register
  a_r6_branch_no_write: assert property (@(posedge clk) disable iff (rst)
    (dec.kind == K_BEQ) |=> $stable(dbg_ra) && $stable(dbg_rb));
endmodule

// File: tb/test_duo_reg_cpu.sv
module test_duo_reg_cpu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       imem_we = 1'b0;
  logic [7:0] imem_waddr = '0;
  logic [7:0] imem_wdata = '0;
  logic       dmem_we = 1'b0;
  logic [3:0] dmem_waddr = '0;
  logic [7:0] dmem_wdata = '0;
  logic [7:0] dbg_pc, dbg_ra, dbg_rb;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  duo_reg_cpu i_duo_reg_cpu (
    .clk(clk), .rst(rst),
    .imem_we(imem_we), .imem_waddr(imem_waddr), .imem_wdata(imem_wdata),
    .dmem_we(dmem_we), .dmem_waddr(dmem_waddr), .dmem_wdata(dmem_wdata),
    .dbg_pc(dbg_pc), .dbg_ra(dbg_ra), .dbg_rb(dbg_rb)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic chk3(input string req, input logic [7:0] p, input logic [7:0] a,
                      input logic [7:0] b);
    chk({req, " pc"}, dbg_pc, p);
    chk({req, " ra"}, dbg_ra, a);
    chk({req, " rb"}, dbg_rb, b);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put_i(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    imem_we = 1'b1; imem_waddr = a; imem_wdata = d;
    @(posedge clk); #1 imem_we = 1'b0;
  endtask

  task automatic put_d(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    dmem_we = 1'b1; dmem_waddr = a; dmem_wdata = d;
    @(posedge clk); #1 dmem_we = 1'b0;
  endtask

  task automatic fresh();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 256; i++) put_i(8'(i), 8'h00);
  endtask

  task automatic go();
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    step();
    chk3("R1 reset", 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_ori();
    fresh();
    put_i(0, 8'hA5); put_i(1, 8'hBC); put_i(2, 8'hAA);
    go();
    step(); chk3("R5 ori ra", 8'h01, 8'h05, 8'h00);
    step(); chk3("R5 ori rb", 8'h02, 8'h05, 8'h0C);
    step(); chk3("R5 ori merge", 8'h03, 8'h0F, 8'h0C);
  endtask

  task automatic t_alu();
    fresh();
    put_i(0, 8'hA9); put_i(1, 8'hB3); put_i(2, 8'h35); put_i(3, 8'h3A);
    put_i(4, 8'h21); put_i(5, 8'h39); put_i(6, 8'h29); put_i(7, 8'h37);
    put_i(8, 8'h30);
    go();
    step(); step(); chk3("R3 setup", 8'h02, 8'h09, 8'h03);
    step(); chk3("R3 add rb=ra+rb", 8'h03, 8'h09, 8'h0C);
    step(); chk3("R3 sub ra=rb-ra", 8'h04, 8'h03, 8'h0C);
    step(); chk3("R3 and ra=ra&rb", 8'h05, 8'h00, 8'h0C);
    step(); chk3("R3 sub wrap", 8'h06, 8'hF4, 8'h0C);
    step(); chk3("R3 or ra=ra|rb", 8'h07, 8'hFC, 8'h0C);
    step(); chk3("R3 add rb=rb+rb", 8'h08, 8'hFC, 8'h18);
    step(); chk3("R3 add overflow", 8'h09, 8'hF8, 8'h18);
    @(negedge clk) rst = 1'b1;
    step(); chk3("R1 reset mid-run", 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_load();
    fresh();
    put_d(4'h0, 8'h5A); put_d(4'hF, 8'hC3);
    put_i(0, 8'h40); put_i(1, 8'h5F);
    go();
    step(); chk3("R4 load ra addr0", 8'h01, 8'h5A, 8'h00);
    step(); chk3("R4 load rb addr15", 8'h02, 8'h5A, 8'hC3);
  endtask

  task automatic t_nop();
    fresh();
    put_i(0, 8'hA7); put_i(1, 8'h00); put_i(2, 8'h1F);
    put_i(3, 8'h60); put_i(4, 8'h80); put_i(5, 8'hC0);
    go();
    step(); chk3("R8 debug after ori", 8'h01, 8'h07, 8'h00);
    for (int k = 2; k <= 6; k++) begin
      step(); chk3("R2 nop/undefined", 8'(k), 8'h07, 8'h00);
    end
  endtask

  task automatic t_beq();
    fresh();
    put_i(0, 8'hE3); put_i(4, 8'hA1); put_i(5, 8'hE5);
    put_i(6, 8'hB1); put_i(7, 8'hF8);
    go();
    step(); chk3("R6 taken forward", 8'h04, 8'h00, 8'h00);
    step(); chk3("R6 setup", 8'h05, 8'h01, 8'h00);
    step(); chk3("R6 not taken", 8'h06, 8'h01, 8'h00);
    step(); chk3("R6 setup2", 8'h07, 8'h01, 8'h01);
    step(); chk3("R6 taken backward", 8'h00, 8'h01, 8'h01);
    step(); chk3("R6 taken again", 8'h04, 8'h01, 8'h01);
  endtask

  task automatic t_wrap();
    fresh();
    put_i(0, 8'hEF); put_i(16, 8'hF0); put_i(17, 8'hF0);
    go();
    step(); chk("R6 offset +15", dbg_pc, 8'h10);
    step(); chk("R6 offset -16", dbg_pc, 8'h01);
    @(negedge clk) rst = 1'b1;
    put_i(1, 8'hF0);
    go();
    step(); chk("R6 setup wrap", dbg_pc, 8'h10);
    step(); chk("R6 setup wrap2", dbg_pc, 8'h01);
    step(); chk("R6 target modulo 256", dbg_pc, 8'hF2);
    for (int k = 0; k < 13; k++) step();
    chk("R9 reach top", dbg_pc, 8'hFF);
    step(); chk("R9 wrap to zero", dbg_pc, 8'h00);
  endtask

  task automatic t_collide();
    fresh();
    put_d(4'h3, 8'h11);
    put_i(0, 8'h43); put_i(1, 8'h53);
    @(negedge clk);
    rst = 1'b0;
    dmem_we = 1'b1; dmem_waddr = 4'h3; dmem_wdata = 8'h99;
    step();
    dmem_we = 1'b0;
    chk("R7 load sees old word", dbg_ra, 8'h11);
    step();
    chk("R7 load sees new word", dbg_rb, 8'h99);
    chk("R7 ra unchanged", dbg_ra, 8'h11);
  endtask

  initial begin
    t_reset();
    t_ori();
    t_alu();
    t_load();
    t_nop();
    t_beq();
    t_wrap();
    t_collide();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got running expected finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule